// File: doc/BRIEF.md
# GPIO Interrupt Controller

This block controls a bank of general-purpose pins, up to 32 of them, through a plain 32-bit register port made of a byte address, a write strobe, write data and combinational read data. Each line has a configuration word of its own. The word switches the output driver, the input path, the output buffer and the interrupt on or off, and it selects one of five trigger conditions. The controller passes every input pin through a two-flop synchronizer. It drives the pin values and their output enables from an output data register.

Trigger events on lines that have the interrupt enabled are latched into a pending register. Software clears a pending bit by writing a one to it. The pending lines leave the block in two forms: a vector with one bit per line, and a single line that is high when any of them is pending. A build parameter moves the input and output data registers to an alternate pair of offsets. A second parameter sets how many lines exist.

Top module: `gpio_irq_ctl`

## Requirements
- R1: After reset every configuration word, the output data register and the pending register read zero, and pinOe, irqVec and irqAny are low.
- R2: The configuration word of line i sits at byte offset 4*i. Bit 0 is output enable, bit 1 is input enable, bit 2 is buffer enable, bit 3 is interrupt enable, and bits [7:5] are the trigger code. A write stores bits [7:5] and [3:0]; every other bit reads back as zero.
- R3: pinOe[i] is high only when both output enable and buffer enable of line i are set. pinOut[i] follows bit i of the output data register.
- R4: The input data register returns, for each line with input enable set, the pin value after two clock edges of synchronization, and zero for lines without it. It sits at offset 0x84, or at 0x90 when ALT_MAP is 1.
- R5: The output data register is read-write. It sits at offset 0x88, or at 0xA0 when ALT_MAP is 1.
- R6: Trigger code 000 (high level) and 001 (low level) set the pending bit on every cycle the level is active, so a clear has no lasting effect while the level persists.
- R7: Trigger code 010 (rising), 011 (falling) and 100 (either edge) set the pending bit once for each qualifying edge. The bit is readable three clock edges after the pin changes.
- R8: The pending register at offset 0x80 clears the bits written as one and keeps the bits written as zero. A new event in the same cycle as a clear leaves the bit set.
- R9: A line with interrupt enable clear never sets its pending bit. irqVec shows the pending bits of enabled lines, and irqAny is high exactly when irqVec is non-zero.
- R10: Reads of misaligned or unmapped offsets, and of configuration words for lines at or above NUM_LINES, return zero, and writes to them change nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| busAddr | input | ADDR_W | Byte address of the register access |
| busWe | input | 1 | Write strobe, taken on the rising clock edge |
| busWdata | input | 32 | Write data |
| busRdata | output | 32 | Read data for busAddr, combinational |
| pinIn | input | NUM_LINES | Asynchronous pin inputs |
| pinOut | output | NUM_LINES | Pin output values |
| pinOe | output | NUM_LINES | Pin output enables |
| irqVec | output | NUM_LINES | Pending interrupts of enabled lines, one per line |
| irqAny | output | 1 | OR of all bits of irqVec |

## Verification
A register write takes effect on the edge that samples it, so read data, pinOut and pinOe are due in the same half cycle that follows that edge. A pin change shows in the input data register after two edges and in the pending register after three edges. The bench changes pins and bus inputs on the falling edge and counts rising edges from there. It samples at the falling edge both one cycle before and at the cycle a result is due, so an early result is caught as well as a late one. The clear-race case places the clearing write on exactly the third edge after the pin change.

// File: rtl/gpio_irq_pkg.sv
package gpio_irq_pkg;
  localparam int MaxLines = 32;

  // Trigger codes held in configuration bits [7:5]
  localparam logic [2:0] TrigHigh = 3'd0;
  localparam logic [2:0] TrigLow  = 3'd1;
  localparam logic [2:0] TrigRise = 3'd2;
  localparam logic [2:0] TrigFall = 3'd3;
  localparam logic [2:0] TrigBoth = 3'd4;

  // Bits of a configuration word that are stored
  localparam logic [7:0] CfgMask = 8'hEF;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_CFG,
    RD_STAT,
    RD_IN,
    RD_OUT
  } rdSel_e;

  typedef struct packed {
    logic       cfgWr;
    logic [4:0] line;
    logic       outWr;
    logic       statClr;
    rdSel_e     rdSel;
  } strobe_t;
endpackage

// File: rtl/gpio_irq_decode.sv
module gpio_irq_decode
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8,
  parameter bit ALT_MAP   = 1'b0
) (
  input  logic [ADDR_W-1:0] busAddr,
  input  logic              busWe,
  output strobe_t           strobes
);
  localparam logic [ADDR_W-1:0] CfgEnd  = ADDR_W'(4 * NUM_LINES);
  localparam logic [ADDR_W-1:0] StatOff = ADDR_W'(8'h80);
  localparam logic [ADDR_W-1:0] InOff   = ALT_MAP ? ADDR_W'(8'h90) : ADDR_W'(8'h84);
  localparam logic [ADDR_W-1:0] OutOff  = ALT_MAP ? ADDR_W'(8'hA0) : ADDR_W'(8'h88);

  logic aligned;
  assign aligned = (busAddr[1:0] == 2'b00);

  always_comb begin
    strobes       = '0;
    strobes.rdSel = RD_NONE;
    if (aligned) begin
      if (busAddr < CfgEnd) begin
        strobes.line  = busAddr[6:2];
        strobes.cfgWr = busWe;
        strobes.rdSel = RD_CFG;
      end else if (busAddr == StatOff) begin
        strobes.statClr = busWe;
        strobes.rdSel   = RD_STAT;
      end else if (busAddr == InOff) begin
        strobes.rdSel = RD_IN;
      end else if (busAddr == OutOff) begin
        strobes.outWr = busWe;
        strobes.rdSel = RD_OUT;
      end
    end
  end
endmodule

// File: rtl/gpio_irq_datapath.sv
module gpio_irq_datapath
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  strobe_t              strobes,
  input  logic [31:0]          wdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic [NUM_LINES-1:0] irqVec,
  output logic                 irqAny,
  output logic [31:0]          rdata
);
  logic [NUM_LINES-1:0][7:0] cfgQ;
  logic [NUM_LINES-1:0]      outQ;
  logic [NUM_LINES-1:0]      statQ;
  logic [NUM_LINES-1:0]      sync1Q;
  logic [NUM_LINES-1:0]      syncQ;
  logic [NUM_LINES-1:0]      prevQ;
  logic [NUM_LINES-1:0]      evt;
  logic [NUM_LINES-1:0]      inEnVec;
  logic [NUM_LINES-1:0]      irqEnVec;
  logic [NUM_LINES-1:0]      clrMask;
  logic [NUM_LINES-1:0]      riseVec;
  logic [NUM_LINES-1:0]      fallVec;
  logic [7:0]                cfgSel;

  // Configuration words
  always_ff @(posedge clk) begin
    if (!rstN) begin
      cfgQ <= '0;
    end else if (strobes.cfgWr) begin
      for (int i = 0; i < NUM_LINES; i++) begin
        if (strobes.line == 5'(i)) cfgQ[i] <= wdata[7:0] & CfgMask;
      end
    end
  end

  // Output data register
  always_ff @(posedge clk) begin
    if (!rstN)              outQ <= '0;
    else if (strobes.outWr) outQ <= wdata[NUM_LINES-1:0];
  end

  // Two-flop synchronizer plus one stage of history for edges
  always_ff @(posedge clk) begin
    if (!rstN) begin
      sync1Q <= '0;
      syncQ  <= '0;
      prevQ  <= '0;
    end else begin
      sync1Q <= pinIn;
      syncQ  <= sync1Q;
      prevQ  <= syncQ;
    end
  end

  assign riseVec = syncQ & ~prevQ;
  assign fallVec = ~syncQ & prevQ;

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic [2:0] trig;
    logic       hit;
    assign trig = cfgQ[i][7:5];
    always_comb begin
      case (trig)
        TrigHigh: hit = syncQ[i];
        TrigLow:  hit = ~syncQ[i];
        TrigRise: hit = riseVec[i];
        TrigFall: hit = fallVec[i];
        TrigBoth: hit = riseVec[i] | fallVec[i];
        default:  hit = 1'b0;
      endcase
    end
    assign irqEnVec[i] = cfgQ[i][3];
    assign inEnVec[i]  = cfgQ[i][1];
    assign pinOe[i]    = cfgQ[i][0] & cfgQ[i][2];
    assign evt[i]      = irqEnVec[i] & hit;
  end

  // Pending register: clear first, then new events win
  assign clrMask = strobes.statClr ? wdata[NUM_LINES-1:0] : '0;

  always_ff @(posedge clk) begin
    if (!rstN) statQ <= '0;
    else       statQ <= (statQ & ~clrMask) | evt;
  end

  assign pinOut = outQ;
  assign irqVec = statQ & irqEnVec;
  assign irqAny = |irqVec;

  // Readback
  always_comb begin
    cfgSel = '0;
    for (int i = 0; i < NUM_LINES; i++) begin
      if (strobes.line == 5'(i)) cfgSel = cfgQ[i];
    end
  end

  always_comb begin
    case (strobes.rdSel)
      RD_CFG:  rdata = {24'b0, cfgSel};
      RD_STAT: rdata = 32'(statQ);
      RD_IN:   rdata = 32'(syncQ & inEnVec);
      RD_OUT:  rdata = 32'(outQ);
      default: rdata = '0;
    endcase
  end
endmodule

// File: rtl/gpio_irq_ctl.sv
module gpio_irq_ctl
  import gpio_irq_pkg::*;
#(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8,
  parameter bit ALT_MAP   = 1'b0
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic [ADDR_W-1:0]    busAddr,
  input  logic                 busWe,
  input  logic [31:0]          busWdata,
  output logic [31:0]          busRdata,
  input  logic [NUM_LINES-1:0] pinIn,
  output logic [NUM_LINES-1:0] pinOut,
  output logic [NUM_LINES-1:0] pinOe,
  output logic [NUM_LINES-1:0] irqVec,
  output logic                 irqAny
);
  strobe_t strobes;

  gpio_irq_decode #(
    .NUM_LINES(NUM_LINES),
    .ADDR_W   (ADDR_W),
    .ALT_MAP  (ALT_MAP)
  ) u_decode (
    .busAddr(busAddr),
    .busWe  (busWe),
    .strobes(strobes)
  );

  gpio_irq_datapath #(
    .NUM_LINES(NUM_LINES)
  ) u_datapath (
    .clk    (clk),
    .rstN   (rstN),
    .strobes(strobes),
    .wdata  (busWdata),
    .pinIn  (pinIn),
    .pinOut (pinOut),
    .pinOe  (pinOe),
    .irqVec (irqVec),
    .irqAny (irqAny),
    .rdata  (busRdata)
  );
endmodule

// File: rtl/gpio_irq_ctl_chk.sv
module gpio_irq_ctl_chk #(
  parameter int NUM_LINES = 32,
  parameter int ADDR_W    = 8
) (
  input logic                 clk,
  input logic                 rstN,
  input logic [ADDR_W-1:0]    busAddr,
  input logic                 busWe,
  input logic [31:0]          busRdata,
  input logic [NUM_LINES-1:0] pinOut,
  input logic [NUM_LINES-1:0] pinOe,
  input logic [NUM_LINES-1:0] irqVec,
  input logic                 irqAny
);
  // R1
  reset_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(rstN) |-> (irqVec == '0 && pinOe == '0 && pinOut == '0 && !irqAny));

  // R9
  any_line_chk: assert property (@(posedge clk) disable iff (!rstN)
    irqAny == (irqVec != '0));

  // R8
  pending_hold_chk: assert property (@(posedge clk) disable iff (!rstN)
    (|($past(irqVec) & ~irqVec)) |-> $past(busWe));

  // R3
  pin_drive_stable_chk: assert property (@(posedge clk) disable iff (!rstN)
    !$past(busWe) |-> ($stable(pinOe) && $stable(pinOut)));

  // R10
  unmapped_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (busAddr[1:0] != 2'b00 || busAddr > ADDR_W'(8'hA0)) |-> busRdata == '0);
endmodule

bind gpio_irq_ctl gpio_irq_ctl_chk #(
  .NUM_LINES(NUM_LINES),
  .ADDR_W   (ADDR_W)
) u_chk (
  .clk     (clk),
  .rstN    (rstN),
  .busAddr (busAddr),
  .busWe   (busWe),
  .busRdata(busRdata),
  .pinOut  (pinOut),
  .pinOe   (pinOe),
  .irqVec  (irqVec),
  .irqAny  (irqAny)
);

// File: tb/gpio_irq_ctl_tb.sv
module gpio_irq_ctl_tb;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [7:0]  busAddr = '0;
  logic        busWe = 1'b0;
  logic [31:0] busWdata = '0;
  logic [31:0] busRdata;
  logic [31:0] pinIn = '0;
  logic [31:0] pinOut, pinOe, irqVec;
  logic        irqAny;

  logic [7:0]  altAddr = '0;
  logic        altWe = 1'b0;
  logic [31:0] altWdata = '0;
  logic [31:0] altRdata;
  logic [7:0]  altPinIn = '0;
  logic [7:0]  altPinOut, altPinOe, altIrqVec;
  logic        altIrqAny;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  gpio_irq_ctl u_dut (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWe(busWe),
    .busWdata(busWdata), .busRdata(busRdata), .pinIn(pinIn),
    .pinOut(pinOut), .pinOe(pinOe), .irqVec(irqVec), .irqAny(irqAny)
  );

  gpio_irq_ctl #(.NUM_LINES(8), .ADDR_W(8), .ALT_MAP(1'b1)) u_alt (
    .clk(clk), .rstN(rstN), .busAddr(altAddr), .busWe(altWe),
    .busWdata(altWdata), .busRdata(altRdata), .pinIn(altPinIn),
    .pinOut(altPinOut), .pinOe(altPinOe), .irqVec(altIrqVec), .irqAny(altIrqAny)
  );

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(posedge clk);
    @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    busAddr = a; busWdata = d; busWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    busWe = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    busAddr = a;
    #1 d = busRdata;
  endtask

  task automatic wrAlt(input logic [7:0] a, input logic [31:0] d);
    altAddr = a; altWdata = d; altWe = 1'b1;
    @(posedge clk);
    @(negedge clk);
    altWe = 1'b0;
  endtask

  task automatic rdAlt(input logic [7:0] a, output logic [31:0] d);
    altAddr = a;
    #1 d = altRdata;
  endtask

  task automatic tReset();
    logic [31:0] v;
    rd(8'h00, v); check("R1 cfg0", v, 0);
    rd(8'h7C, v); check("R1 cfg31", v, 0);
    rd(8'h80, v); check("R1 pending", v, 0);
    rd(8'h88, v); check("R1 outdata", v, 0);
    check("R1 pinOe", pinOe, 0);
    check("R1 irq", {irqVec[30:0], irqAny}, 0);
  endtask

  task automatic tConfig();
    logic [31:0] v;
    wr(8'h14, 32'hFFFF_FFFF);
    rd(8'h14, v); check("R2 stored bits", v, 32'h0000_00EF);
    wr(8'h14, 32'h05);
    wr(8'h18, 32'h01);
    wr(8'h88, 32'h0000_0060);
    check("R3 pinOe", pinOe & 32'h60, 32'h20);
    check("R3 pinOut", pinOut & 32'h60, 32'h60);
    rd(8'h88, v); check("R5 outdata readback", v, 32'h60);
  endtask

  task automatic tInput();
    logic [31:0] v;
    wr(8'h08, 32'h02);
    pinIn[2] = 1'b1; pinIn[3] = 1'b1;
    cyc(1);
    rd(8'h84, v); check("R4 after one edge", v & 32'hC, 0);
    cyc(1);
    rd(8'h84, v); check("R4 after two edges, gated", v & 32'hC, 32'h4);
  endtask

  task automatic tLevel();
    logic [31:0] v;
    wr(8'h20, 32'h08);
    pinIn[8] = 1'b1;
    cyc(3);
    rd(8'h80, v); check("R6 level high pending", v & 32'h100, 32'h100);
    check("R9 irqVec and irqAny", {irqVec[8], irqAny}, 2'b11);
    wr(8'h80, 32'h100);
    rd(8'h80, v); check("R6 clear ignored while active", v & 32'h100, 32'h100);
    pinIn[8] = 1'b0;
    cyc(3);
    wr(8'h80, 32'h100);
    rd(8'h80, v); check("R6 clear after inactive", v & 32'h100, 0);
    wr(8'h24, 32'h28);
    cyc(1);
    rd(8'h80, v); check("R6 level low pending", v & 32'h200, 32'h200);
    pinIn[9] = 1'b1;
    cyc(3);
    wr(8'h80, 32'h200);
    rd(8'h80, v); check("R6 level low cleared", v & 32'h200, 0);
  endtask

  task automatic tEdge();
    logic [31:0] v;
    wr(8'h28, 32'h48);
    pinIn[10] = 1'b1;
    cyc(2);
    rd(8'h80, v); check("R7 rise not yet", v & 32'h400, 0);
    cyc(1);
    rd(8'h80, v); check("R7 rise on third edge", v & 32'h400, 32'h400);
    wr(8'h80, 32'h400);
    cyc(3);
    rd(8'h80, v); check("R7 once per edge", v & 32'h400, 0);
    wr(8'h2C, 32'h68);
    pinIn[11] = 1'b1;
    cyc(3);
    rd(8'h80, v); check("R7 fall ignores rise", v & 32'h800, 0);
    pinIn[11] = 1'b0;
    cyc(3);
    rd(8'h80, v); check("R7 fall detected", v & 32'h800, 32'h800);
    wr(8'h30, 32'h88);
    pinIn[12] = 1'b1;
    cyc(3);
    rd(8'h80, v); check("R7 both: rise", v & 32'h1000, 32'h1000);
    wr(8'h80, 32'h1000);
    pinIn[12] = 1'b0;
    cyc(3);
    rd(8'h80, v); check("R7 both: fall", v & 32'h1000, 32'h1000);
  endtask

  task automatic tClearRace();
    logic [31:0] v;
    wr(8'h80, 32'hFFFF_FFFF);
    wr(8'h34, 32'h48);
    pinIn[13] = 1'b1;
    cyc(2);
    wr(8'h80, 32'h2000);
    rd(8'h80, v); check("R8 event wins over clear", v & 32'h2000, 32'h2000);
    wr(8'h80, 32'h0);
    rd(8'h80, v); check("R8 zero write keeps", v & 32'h2000, 32'h2000);
    wr(8'h80, 32'h2000);
    rd(8'h80, v); check("R8 one write clears", v & 32'h2000, 0);
  endtask

  task automatic tDisabled();
    logic [31:0] v;
    wr(8'h38, 32'h00);
    pinIn[14] = 1'b1;
    cyc(4);
    rd(8'h80, v); check("R9 disabled line pending", v & 32'h4000, 0);
    check("R9 disabled line irqVec", 32'(irqVec[14]), 0);
  endtask

  task automatic tMap();
    logic [31:0] v;
    rd(8'h81, v); check("R10 misaligned", v, 0);
    rd(8'hFC, v); check("R10 unmapped", v, 0);
    wrAlt(8'h24, 32'h0F);
    rdAlt(8'h24, v); check("R10 line above count", v, 0);
    wrAlt(8'hA0, 32'h5A);
    rdAlt(8'hA0, v); check("R5 alternate outdata", v, 32'h5A);
    check("R10 above-count write leaves pins", 32'(altPinOe), 0);
    rdAlt(8'h88, v); check("R10 default offset unused in alt map", v, 0);
    wrAlt(8'h00, 32'h02);
    altPinIn[0] = 1'b1;
    cyc(2);
    rdAlt(8'h90, v); check("R4 alternate indata", v, 32'h1);
  endtask

  initial begin
    cyc(3);
    rstN = 1'b1;
    cyc(1);
    tReset();
    tConfig();
    tInput();
    tLevel();
    tEdge();
    tClearRace();
    tDisabled();
    tMap();
    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end
endmodule